// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control unit for a 32-bit datapath that runs each instruction over several clock cycles. The datapath has one memory for both code and data and one ALU, which also advances the program counter. Holding registers keep values from one cycle to the next: the instruction, the memory read data, the two source operands and the ALU result. The controller is a Moore state machine. Each cycle it drives every multiplexer select and write enable of that datapath. Its only inputs are the opcode taken from the held instruction and the ALU zero flag.

Four instruction classes are sequenced, and each takes its own number of cycles. A conditional branch on equality takes three cycles. A register-to-register operation and a store each take four. A load takes five. Every instruction starts with the same two cycles. The first fetches the instruction and adds 4 to the PC. The second reads both source registers and, before the opcode has been examined, uses the ALU to compute a branch target from the immediate. The remaining cycles depend on the instruction class. An opcode the controller does not handle goes back to fetch after the second cycle.

The controller has no datapath logic of its own. The only output that looks at an input combinationally is the final PC load strobe. It merges the unconditional PC write with the branch write, and the branch write is gated by the zero flag.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the controller is in the fetch step: mem_rd=1, ir_wr=1, pc_write=1, pc_load=1, addr_sel=0 (PC addresses memory), alu_a_sel=0 (PC), alu_b_sel=1 (constant 4), alu_op=0 (add), pc_src_sel=0 (ALU result), and every other output is 0.
- R2: The cycle after fetch is the decode step, whatever the opcode: alu_a_sel=0, alu_b_sel=3 (immediate shifted left 2), alu_op=0, and every enable is 0. Two adjacent cycles never both assert ir_wr.
- R3: A load (opcode 35) runs five cycles: fetch, decode, address (alu_a_sel=1, alu_b_sel=2 for the sign-extended immediate, alu_op=0), memory read (addr_sel=1, mem_rd=1), then write-back (reg_wr=1, wb_sel=1 for memory data, reg_dst_sel=0 for the rt field). It then returns to fetch.
- R4: A store (opcode 43) runs four cycles: fetch, decode, address as in R3, then memory write (addr_sel=1, mem_wr=1). It then returns to fetch.
- R5: A register operation (opcode 0) runs four cycles: fetch, decode, execute (alu_a_sel=1, alu_b_sel=0 for B, alu_op=2 to use the function field), then write-back (reg_wr=1, reg_dst_sel=1 for the rd field, wb_sel=0 for the ALU result).
- R6: A branch on equal (opcode 4) runs three cycles: fetch, decode, completion (alu_a_sel=1, alu_b_sel=0, alu_op=1 for subtract, pc_src_sel=1 for the held ALU result, pc_write_cond=1). In completion, pc_load equals alu_zero.
- R7: Any other opcode returns to fetch directly after decode, two cycles in total.
- R8: Only pc_load depends on alu_zero, and only in branch completion. All other outputs follow the state alone, so changing alu_zero or the opcode within a cycle leaves them unchanged.
- R9: mem_rd and mem_wr are never both 1, and no cycle asserts both a memory access and reg_wr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write if the branch is taken |
| pc_load | output | 1 | Final PC load strobe |
| pc_src_sel | output | 1 | PC source: 0 ALU result, 1 held ALU result |
| addr_sel | output | 1 | Memory address: 0 PC, 1 held ALU result |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU result, 1 memory data |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 constant 4, 2 immediate, 3 immediate shifted left 2 |
| alu_op | output | 2 | 0 add, 1 subtract, 2 per function field |

## Verification
The assertions check the state transitions on every cycle: fetch always leads to decode, and each terminal step returns to fetch. They also check the load write-back step, the single-cycle instruction load strobe and the exclusion between memory and register writes. Only the bench scenarios can show the full control word in each step of each instruction class. The same holds for the cycle count of each class, the zero-gated PC load in branch completion, the fact that outputs do not react to the inputs within a cycle, and recovery when reset arrives partway through an instruction.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LOAD    = 4'd3,
        ST_LOAD_WB = 4'd4,
        ST_STORE   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_EXEC_WB = 4'd7,
        ST_BRANCH  = 4'd8
    } ctrl_state_e;

    typedef enum logic [2:0] {
        CL_REG    = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_BRANCH = 3'd3,
        CL_OTHER  = 3'd4
    } op_class_e;

    localparam logic [1:0] BSRC_REG   = 2'd0;
    localparam logic [1:0] BSRC_FOUR  = 2'd1;
    localparam logic [1:0] BSRC_IMM   = 2'd2;
    localparam logic [1:0] BSRC_IMMSH = 2'd3;

    localparam logic [1:0] AOP_ADD   = 2'd0;
    localparam logic [1:0] AOP_SUB   = 2'd1;
    localparam logic [1:0] AOP_FUNCT = 2'd2;

    typedef struct packed {
        logic       pc_write;
        logic       pc_write_cond;
        logic       pc_src_sel;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       reg_wr;
        logic       reg_dst_sel;
        logic       wb_sel;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_op;
    } ctrl_word_t;

    typedef struct packed {
        ctrl_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_ctrl_pkg::*;
#(
    parameter int unsigned OP_W = 6,
    parameter logic [OP_W-1:0] OP_REG    = 6'd0,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'd35,
    parameter logic [OP_W-1:0] OP_STORE  = 6'd43,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'd4
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_e       op_cls
);
    always_comb begin
        if (opcode == OP_REG)         op_cls = CL_REG;
        else if (opcode == OP_LOAD)   op_cls = CL_LOAD;
        else if (opcode == OP_STORE)  op_cls = CL_STORE;
        else if (opcode == OP_BRANCH) op_cls = CL_BRANCH;
        else                          op_cls = CL_OTHER;
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e state_q,
    input  op_class_e   op_cls,
    output ctrl_state_e state_nx
);
    always_comb begin
        state_nx = ST_FETCH;
        unique case (state_q)
            ST_FETCH:   state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (op_cls)
                    CL_LOAD, CL_STORE: state_nx = ST_ADDR;
                    CL_REG:            state_nx = ST_EXEC;
                    CL_BRANCH:         state_nx = ST_BRANCH;
                    default:           state_nx = ST_FETCH;
                endcase
            end
            ST_ADDR:    state_nx = (op_cls == CL_LOAD) ? ST_LOAD : ST_STORE;
            ST_LOAD:    state_nx = ST_LOAD_WB;
            ST_EXEC:    state_nx = ST_EXEC_WB;
            ST_LOAD_WB, ST_STORE, ST_EXEC_WB, ST_BRANCH: state_nx = ST_FETCH;
            default:    state_nx = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  ctrl_state_e state_q,
    output ctrl_word_t  cw
);
    always_comb begin
        cw = '0;
        unique case (state_q)
            ST_FETCH: begin
                cw.mem_rd    = 1'b1;
                cw.ir_wr     = 1'b1;
                cw.pc_write  = 1'b1;
                cw.alu_b_sel = BSRC_FOUR;
                cw.alu_op    = AOP_ADD;
            end
            ST_DECODE: begin
                cw.alu_b_sel = BSRC_IMMSH;
                cw.alu_op    = AOP_ADD;
            end
            ST_ADDR: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = BSRC_IMM;
                cw.alu_op    = AOP_ADD;
            end
            ST_LOAD: begin
                cw.addr_sel = 1'b1;
                cw.mem_rd   = 1'b1;
            end
            ST_LOAD_WB: begin
                cw.reg_wr = 1'b1;
                cw.wb_sel = 1'b1;
            end
            ST_STORE: begin
                cw.addr_sel = 1'b1;
                cw.mem_wr   = 1'b1;
            end
            ST_EXEC: begin
                cw.alu_a_sel = 1'b1;
                cw.alu_b_sel = BSRC_REG;
                cw.alu_op    = AOP_FUNCT;
            end
            ST_EXEC_WB: begin
                cw.reg_wr      = 1'b1;
                cw.reg_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                cw.alu_a_sel     = 1'b1;
                cw.alu_b_sel     = BSRC_REG;
                cw.alu_op        = AOP_SUB;
                cw.pc_src_sel    = 1'b1;
                cw.pc_write_cond = 1'b1;
            end
            default: cw = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_ctrl_pkg::*;
#(
    parameter int unsigned OP_W = 6,
    parameter logic [OP_W-1:0] OP_REG    = 6'd0,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'd35,
    parameter logic [OP_W-1:0] OP_STORE  = 6'd43,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'd4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    output logic            pc_write,
    output logic            pc_write_cond,
    output logic            pc_load,
    output logic            pc_src_sel,
    output logic            addr_sel,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_wr,
    output logic            reg_wr,
    output logic            reg_dst_sel,
    output logic            wb_sel,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic [1:0]      alu_op
);
    seq_regs_t   seq_d, seq_q;
    op_class_e   op_cls;
    ctrl_state_e state_nx;
    ctrl_word_t  cw;

    mc_op_class #(
        .OP_W(OP_W), .OP_REG(OP_REG), .OP_LOAD(OP_LOAD),
        .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH)
    ) u_cls (
        .opcode (opcode),
        .op_cls (op_cls)
    );

    mc_next_state u_nxt (
        .state_q  (seq_q.state),
        .op_cls   (op_cls),
        .state_nx (state_nx)
    );

    mc_ctrl_decode u_dec (
        .state_q (seq_q.state),
        .cw      (cw)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.state = state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_FETCH};
        else        seq_q <= seq_d;
    end

    assign pc_write      = cw.pc_write;
    assign pc_write_cond = cw.pc_write_cond;
    assign pc_load       = cw.pc_write | (cw.pc_write_cond & alu_zero);
    assign pc_src_sel    = cw.pc_src_sel;
    assign addr_sel      = cw.addr_sel;
    assign mem_rd        = cw.mem_rd;
    assign mem_wr        = cw.mem_wr;
    assign ir_wr         = cw.ir_wr;
    assign reg_wr        = cw.reg_wr;
    assign reg_dst_sel   = cw.reg_dst_sel;
    assign wb_sel        = cw.wb_sel;
    assign alu_a_sel     = cw.alu_a_sel;
    assign alu_b_sel     = cw.alu_b_sel;
    assign alu_op        = cw.alu_op;

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_FETCH) |=> (seq_q.state == ST_DECODE)); // R2
    AST_IR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ir_wr |=> !ir_wr); // R2
    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_LOAD) |=> (reg_wr && wb_sel)); // R3
    AST_STORE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_STORE) |=> (seq_q.state == ST_FETCH)); // R4
    AST_EXEC_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_EXEC) |=> (reg_wr && reg_dst_sel)); // R5
    AST_BRANCH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_BRANCH) |=> (seq_q.state == ST_FETCH)); // R6
    AST_OTHER_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_DECODE && op_cls == CL_OTHER) |=> ir_wr); // R7
    AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd | mem_wr, reg_wr}) <= 1 && !(mem_rd && mem_wr)); // R9
endmodule

// File: tb/sim_mc_seq_ctrl.sv
module sim_mc_seq_ctrl;
    localparam int PERIOD = 10;
    localparam int NVEC   = 10;

    localparam logic [15:0] W_FETCH = 16'hAA08;
    localparam logic [15:0] W_DEC   = 16'h0018;
    localparam logic [15:0] W_ADDR  = 16'h0030;
    localparam logic [15:0] W_LOAD  = 16'h1800;
    localparam logic [15:0] W_LWB   = 16'h0140;
    localparam logic [15:0] W_STORE = 16'h1400;
    localparam logic [15:0] W_EXEC  = 16'h0024;
    localparam logic [15:0] W_RWB   = 16'h0180;
    localparam logic [15:0] W_BR_NT = 16'h4023;
    localparam logic [15:0] W_BR_T  = 16'h6023;
    localparam logic [15:0] W_NONE  = 16'h0000;

    // entry: opcode[89:84], zero[83], cycles[82:80], five control words
    localparam logic [89:0] VEC [NVEC] = '{
        {6'd35, 1'b0, 3'd5, W_FETCH, W_DEC, W_ADDR, W_LOAD, W_LWB},
        {6'd43, 1'b1, 3'd4, W_FETCH, W_DEC, W_ADDR, W_STORE, W_NONE},
        {6'd0,  1'b0, 3'd4, W_FETCH, W_DEC, W_EXEC, W_RWB, W_NONE},
        {6'd4,  1'b0, 3'd3, W_FETCH, W_DEC, W_BR_NT, W_NONE, W_NONE},
        {6'd4,  1'b1, 3'd3, W_FETCH, W_DEC, W_BR_T, W_NONE, W_NONE},
        {6'd2,  1'b0, 3'd2, W_FETCH, W_DEC, W_NONE, W_NONE, W_NONE},
        {6'd63, 1'b1, 3'd2, W_FETCH, W_DEC, W_NONE, W_NONE, W_NONE},
        {6'd0,  1'b1, 3'd4, W_FETCH, W_DEC, W_EXEC, W_RWB, W_NONE},
        {6'd35, 1'b1, 3'd5, W_FETCH, W_DEC, W_ADDR, W_LOAD, W_LWB},
        {6'd43, 1'b0, 3'd4, W_FETCH, W_DEC, W_ADDR, W_STORE, W_NONE}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic       alu_zero = 1'b0;
    logic pc_write, pc_write_cond, pc_load, pc_src_sel, addr_sel, mem_rd, mem_wr;
    logic ir_wr, reg_wr, reg_dst_sel, wb_sel, alu_a_sel;
    logic [1:0] alu_b_sel, alu_op;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    mc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero),
        .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_load(pc_load),
        .pc_src_sel(pc_src_sel), .addr_sel(addr_sel), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .reg_dst_sel(reg_dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_op(alu_op)
    );

    function automatic logic [15:0] observed();
        return {pc_write, pc_write_cond, pc_load, addr_sel, mem_rd, mem_wr,
                ir_wr, reg_wr, reg_dst_sel, wb_sel, alu_a_sel, alu_b_sel,
                alu_op, pc_src_sel};
    endfunction

    function automatic string req_of(input logic [5:0] op, input int cyc);
        if (cyc == 0) return "R1/R8 fetch";
        if (cyc == 1) return "R2 decode";
        case (op)
            6'd35:   return "R3 load";
            6'd43:   return "R4 store";
            6'd0:    return "R5 register op";
            6'd4:    return "R6 branch";
            default: return "R7 other opcode";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 check("R1 in reset", observed(), W_FETCH);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            logic [89:0] e;
            e = VEC[v];
            opcode   = e[89:84];
            alu_zero = e[83];
            for (int c = 0; c < int'(e[82:80]); c++) begin
                #1 check(req_of(e[89:84], c), observed(), e[79 - 16*c -: 16]);
                // R9: memory and register write exclusion at the ports
                check("R9 exclusion", 16'(((mem_rd | mem_wr) & reg_wr) | (mem_rd & mem_wr)), 16'd0);
                @(negedge clk);
            end
        end

        // R8: within fetch, flipping zero and opcode leaves outputs alone
        #1 check("R8 fetch base", observed(), W_FETCH);
        alu_zero = ~alu_zero; opcode = 6'd17;
        #1 check("R8 fetch inputs flipped", observed(), W_FETCH);
        opcode = 6'd4;
        @(negedge clk);
        #1 check("R2 decode before branch", observed(), W_DEC);
        @(negedge clk);
        alu_zero = 1'b0;
        #1 check("R6 branch not taken", observed(), W_BR_NT);
        alu_zero = 1'b1;
        #1 check("R6 branch taken same cycle", observed(), W_BR_T);
        alu_zero = 1'b0;
        #1 check("R8 pc_load follows zero only", observed(), W_BR_NT);
        @(negedge clk);
        #1 check("R6 branch back to fetch", observed(), W_FETCH);

        // R1: reset in the middle of a load
        opcode = 6'd35;
        repeat (3) @(negedge clk);
        #1 check("R3 load read step", observed(), W_LOAD);
        rst_n = 1'b0;
        #1 check("R1 reset mid-load", observed(), W_FETCH);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 fetch after reset", observed(), W_FETCH);
        @(negedge clk);
        #1 check("R2 decode after reset", observed(), W_DEC);
        @(negedge clk);
        #1 check("R3 address after reset", observed(), W_ADDR);

        finish_run();
    end
endmodule